// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit gathers the event flags of a serial bus controller into one 16-bit status word and turns them into one level interrupt and two DMA request lines. The transfer engine raises flags with one-cycle set pulses. Software reads the status with the live bus-busy level shown in bit 12. It clears selected flags by writing ones to them. It can also take a vector read, which names the lowest-numbered flag that is both pending and enabled, and clears that flag in the same access.

An interrupt-enable mask chooses which flags reach the interrupt line. A DMA-enable word hands the receive and transmit ready flags to the DMA request lines. When DMA is turned on for a direction, that direction's interrupt enable is dropped. A test write can force the six low flags to one. A parameter selects between an older and a newer variant. The two differ in mask width, in whether status writes clear anything, and in whether the force hook works.

Top module: `irq_vector_unit`

## Requirements
- R1: A synchronous reset (`srst` high at a clock edge) sets status, mask and DMA enables to zero; `irq`, `dma_rx_req`, `dma_tx_req` and `vec_code` are then low.
- R2: `irq` is high exactly when some status bit and its mask bit are both set (bit i of the mask enables status bit i).
- R3: `dma_rx_req` equals status bit 3 while DMA-enable bit 15 is set, else 0. `dma_tx_req` equals status bit 4 while DMA-enable bit 7 is set, else 0.
- R4: A DMA-enable write stores only bits 15 and 7 of `wr_data`. If bit 15 is written as one, mask bit 3 is cleared. If bit 7 is written as one, mask bit 4 is cleared. This clearing takes effect even over a mask write in the same cycle.
- R5: `vec_code` is 1 + the index of the lowest set bit of (status AND mask), or 0 if none. A `vec_rd` pulse clears that one status bit at the clock edge and leaves the others unchanged.
- R6: In the newer variant, a status write clears the status bits set in (`wr_data` AND 0x0027). Bits 3 and 4 and all other bits are untouched. In the older variant, a status write has no effect.
- R7: `stat_rdata` returns the stored status with bit 12 replaced by the current `bus_busy` level.
- R8: A mask write keeps `wr_data` bits 5:0 in the newer variant and bits 4:0 in the older one; the other mask bits read 0.
- R9: In the newer variant, a test write with `wr_data` bit 11 set forces status bits 5:0 to one. In the older variant, or with bit 11 clear, the test write changes nothing.
- R10: A set pulse on a bit in the same cycle as a vector read or status write that would clear it leaves the bit set.
- R11: Each set pulse bit in `evt_set` sets the matching status bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| evt_set | input | 16 | One-cycle set pulses, one per status bit |
| bus_busy | input | 1 | Live bus-busy level, shown in status bit 12 |
| wr_data | input | 16 | Write data shared by all write strobes |
| mask_wr | input | 1 | Write the interrupt-enable mask |
| dma_wr | input | 1 | Write the DMA-enable word |
| stat_wr | input | 1 | Write-one-to-clear status access |
| test_wr | input | 1 | Test write (bit 11 forces flags) |
| vec_rd | input | 1 | Vector read; clears the reported flag |
| stat_rdata | output | 16 | Status with live busy bit |
| mask_rdata | output | 8 | Current mask |
| dma_rdata | output | 16 | Current DMA-enable word |
| vec_code | output | 5 | Lowest pending enabled flag index + 1, or 0 |
| irq | output | 1 | Combined interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The clocked checks assume that the strobes and set pulses are valid on every rising edge and hold no unknown values once reset has been applied. The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. The vector-clear check applies only when no set pulse or force hits the reported bit in the same cycle, because R10 lets those win. The bench drives such collisions on purpose and checks their result at the ports instead. Both variants receive the same stimulus, so that each difference between them shows up at the outputs.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    // bit positions that behaviour depends on
    localparam int RX_RDY_BIT     = 3;
    localparam int TX_RDY_BIT     = 4;
    localparam int BUSY_BIT       = 12;
    localparam int RX_DMA_BIT     = 15;
    localparam int TX_DMA_BIT     = 7;
    localparam int FORCE_TRIG_BIT = 11;
    localparam int FORCE_COUNT    = 6;
    localparam int NEW_MASK_BITS  = 6;
    localparam int OLD_MASK_BITS  = 5;
    localparam logic [15:0] W1C_SEL = 16'h0027;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_VEC  = 2'b01,
        CLR_W1C  = 2'b10,
        CLR_BOTH = 2'b11
    } clr_src_e;
endpackage

// File: rtl/irqv_prio.sv
module irqv_prio #(
    parameter int DW = 16,
    parameter int CW = 5
) (
    input  logic [DW-1:0] req,
    output logic [DW-1:0] lowest_oh,
    output logic [CW-1:0] code
);
    // one-hot of the lowest requesting bit
    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_oh
            if (g == 0) begin : g_first
                assign lowest_oh[g] = req[g];
            end else begin : g_rest
                assign lowest_oh[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    // index + 1 of the selected bit, zero when idle
    always_comb begin
        code = '0;
        for (int i = 0; i < DW; i++) begin
            if (lowest_oh[i]) begin
                code = code | CW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irqv_cfg.sv
module irqv_cfg
    import irqv_pkg::*;
#(
    parameter int DW          = 16,
    parameter int MW          = 8,
    parameter bit NEW_VARIANT = 1'b1
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          mask_wr,
    input  logic          dma_wr,
    input  logic [DW-1:0] wr_data,
    output logic [MW-1:0] mask_q,
    output logic [DW-1:0] dma_q
);
    localparam int          KEEP_BITS = NEW_VARIANT ? NEW_MASK_BITS : OLD_MASK_BITS;
    localparam logic [MW-1:0] MASK_KEEP = MW'((1 << KEEP_BITS) - 1);
    localparam logic [DW-1:0] DMA_KEEP  = DW'(1 << RX_DMA_BIT) | DW'(1 << TX_DMA_BIT);

    logic [MW-1:0] mask_d;
    logic [DW-1:0] dma_d;

    always_comb begin
        mask_d = mask_q;
        dma_d  = dma_q;
        if (mask_wr) begin
            mask_d = wr_data[MW-1:0] & MASK_KEEP;
        end
        if (dma_wr) begin
            dma_d = wr_data & DMA_KEEP;
            if (wr_data[RX_DMA_BIT]) mask_d[RX_RDY_BIT] = 1'b0;
            if (wr_data[TX_DMA_BIT]) mask_d[TX_RDY_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            mask_q <= '0;
            dma_q  <= '0;
        end else begin
            mask_q <= mask_d;
            dma_q  <= dma_d;
        end
    end

    // R4
    dma_rx_mask_chk: assert property (@(posedge clk) disable iff (srst)
        dma_wr && wr_data[RX_DMA_BIT] |=> !mask_q[RX_RDY_BIT]);

    // R4
    dma_tx_mask_chk: assert property (@(posedge clk) disable iff (srst)
        dma_wr && wr_data[TX_DMA_BIT] |=> !mask_q[TX_RDY_BIT]);
endmodule

// File: rtl/irqv_status.sv
module irqv_status #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          srst,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    input  logic [DW-1:0] force_i,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] stat_d;

    // set pulses and forcing take priority over clearing
    always_comb begin
        stat_d = (stat_q & ~clr_i) | set_i | force_i;
    end

    always_ff @(posedge clk) begin
        if (srst) stat_q <= '0;
        else      stat_q <= stat_d;
    end

    // R10 R11
    set_keep_chk: assert property (@(posedge clk) disable iff (srst)
        (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int STAT_W      = 16,
    parameter int MASK_W      = 8,
    parameter bit NEW_VARIANT = 1'b1,
    localparam int CODE_W     = $clog2(STAT_W + 1)
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              bus_busy,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              mask_wr,
    input  logic              dma_wr,
    input  logic              stat_wr,
    input  logic              test_wr,
    input  logic              vec_rd,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [MASK_W-1:0] mask_rdata,
    output logic [STAT_W-1:0] dma_rdata,
    output logic [CODE_W-1:0] vec_code,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    localparam logic [STAT_W-1:0] W1C_MASK   = STAT_W'(W1C_SEL);
    localparam logic [STAT_W-1:0] FORCE_MASK = STAT_W'((1 << FORCE_COUNT) - 1);
    localparam logic [STAT_W-1:0] RDY_PAIR   = STAT_W'(1 << RX_RDY_BIT) | STAT_W'(1 << TX_RDY_BIT);

    logic [STAT_W-1:0] stat_q;
    logic [MASK_W-1:0] mask_q;
    logic [STAT_W-1:0] dma_q;
    logic [STAT_W-1:0] pending;
    logic [STAT_W-1:0] lowest_oh;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] force_vec;
    clr_src_e          clr_src;

    assign pending = stat_q & STAT_W'(mask_q);

    irqv_cfg #(
        .DW         (STAT_W),
        .MW         (MASK_W),
        .NEW_VARIANT(NEW_VARIANT)
    ) u_cfg (
        .clk    (clk),
        .srst   (srst),
        .mask_wr(mask_wr),
        .dma_wr (dma_wr),
        .wr_data(wr_data),
        .mask_q (mask_q),
        .dma_q  (dma_q)
    );

    irqv_prio #(
        .DW(STAT_W),
        .CW(CODE_W)
    ) u_prio (
        .req      (pending),
        .lowest_oh(lowest_oh),
        .code     (vec_code)
    );

    // which clear sources act this cycle
    always_comb begin
        clr_src = clr_src_e'({stat_wr && NEW_VARIANT, vec_rd});
    end

    always_comb begin
        unique case (clr_src)
            CLR_NONE: clr_vec = '0;
            CLR_VEC:  clr_vec = lowest_oh;
            CLR_W1C:  clr_vec = wr_data & W1C_MASK;
            CLR_BOTH: clr_vec = lowest_oh | (wr_data & W1C_MASK);
            default:  clr_vec = '0;
        endcase
    end

    always_comb begin
        force_vec = '0;
        if (NEW_VARIANT && test_wr && wr_data[FORCE_TRIG_BIT]) begin
            force_vec = FORCE_MASK;
        end
    end

    irqv_status #(
        .DW(STAT_W)
    ) u_status (
        .clk    (clk),
        .srst   (srst),
        .set_i  (evt_set),
        .clr_i  (clr_vec),
        .force_i(force_vec),
        .stat_q (stat_q)
    );

    always_comb begin
        stat_rdata           = stat_q;
        stat_rdata[BUSY_BIT] = bus_busy;
    end

    assign mask_rdata = mask_q;
    assign dma_rdata  = dma_q;
    assign irq        = |pending;
    assign dma_rx_req = dma_q[RX_DMA_BIT] & stat_q[RX_RDY_BIT];
    assign dma_tx_req = dma_q[TX_DMA_BIT] & stat_q[TX_RDY_BIT];

    // R2
    irq_code_chk: assert property (@(posedge clk) disable iff (srst)
        irq == (vec_code != '0));

    // R5
    vec_onehot_chk: assert property (@(posedge clk) disable iff (srst)
        $onehot0(lowest_oh));

    // R5
    vec_clear_chk: assert property (@(posedge clk) disable iff (srst)
        vec_rd && !test_wr && (vec_code != '0) && ((lowest_oh & evt_set) == '0)
        |=> ((stat_q & $past(lowest_oh)) == '0));

    // R6
    rdy_hold_chk: assert property (@(posedge clk) disable iff (srst)
        stat_wr && !vec_rd
        |=> ((stat_q & RDY_PAIR & $past(stat_q)) == ($past(stat_q) & RDY_PAIR)));
endmodule

// File: tb/irq_vector_unit_test.sv
`timescale 1ns/1ps
module irq_vector_unit_test;
    logic        clk = 1'b0;
    logic        srst;
    logic [15:0] evt_set, wr_data;
    logic        bus_busy, mask_wr, dma_wr, stat_wr, test_wr, vec_rd;
    logic [15:0] stat_rdata, dma_rdata, o_stat, o_dma;
    logic [7:0]  mask_rdata, o_mask;
    logic [4:0]  vec_code, o_code;
    logic        irq, dma_rx_req, dma_tx_req, o_irq, o_rx, o_tx;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_vector_unit uut (
        .clk(clk), .srst(srst), .evt_set(evt_set), .bus_busy(bus_busy),
        .wr_data(wr_data), .mask_wr(mask_wr), .dma_wr(dma_wr),
        .stat_wr(stat_wr), .test_wr(test_wr), .vec_rd(vec_rd),
        .stat_rdata(stat_rdata), .mask_rdata(mask_rdata), .dma_rdata(dma_rdata),
        .vec_code(vec_code), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    irq_vector_unit #(.NEW_VARIANT(1'b0)) uut_old (
        .clk(clk), .srst(srst), .evt_set(evt_set), .bus_busy(bus_busy),
        .wr_data(wr_data), .mask_wr(mask_wr), .dma_wr(dma_wr),
        .stat_wr(stat_wr), .test_wr(test_wr), .vec_rd(vec_rd),
        .stat_rdata(o_stat), .mask_rdata(o_mask), .dma_rdata(o_dma),
        .vec_code(o_code), .irq(o_irq), .dma_rx_req(o_rx), .dma_tx_req(o_tx)
    );

    // row: op[55:52] data[51:36] stat[35:20] mask[19:12] code[11:4] irq,rx,tx,0 [3:0]
    // op: 0 set pulse, 1 mask write, 2 dma write, 3 status write, 4 vector read, 5 test write
    localparam int NROWS = 17;
    localparam logic [55:0] TBL [NROWS] = '{
        56'h0_0019_0019_00_00_0,  // R11 set pulses
        56'h1_00FF_0019_3F_01_8,  // R8 mask width, R2
        56'h4_0000_0018_3F_04_8,  // R5 vector clears bit 0
        56'h2_8000_0018_37_05_C,  // R4 rx dma drops mask bit 3, R3
        56'h2_FFFF_0018_27_00_6,  // R4 tx dma drops mask bit 4
        56'h3_FFFF_0018_27_00_6,  // R6 ready bits survive
        56'h5_0800_003F_27_01_E,  // R9 force
        56'h3_0022_001D_27_01_E,  // R6 clear bits 1 and 5
        56'h4_0000_001C_27_03_E,  // R5
        56'h4_0000_0018_27_00_6,  // R5
        56'h4_0000_0018_27_00_6,  // R5 nothing pending
        56'h5_0000_0018_27_00_6,  // R9 no trigger bit
        56'h2_0000_0018_27_00_0,  // R3 dma off
        56'h1_0018_0018_18_04_8,  // R2
        56'h0_8000_8018_18_04_8,  // R11
        56'h3_8000_8018_18_04_8,  // R6 bit 15 not clearable
        56'h1_0000_8018_00_00_0   // R2 masked off
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        evt_set = '0; wr_data = '0; mask_wr = 0; dma_wr = 0;
        stat_wr = 0; test_wr = 0; vec_rd = 0;
    endtask

    task automatic do_op(input logic [3:0] op, input logic [15:0] d);
        idle();
        case (op)
            4'd0: evt_set = d;
            4'd1: begin mask_wr = 1; wr_data = d; end
            4'd2: begin dma_wr  = 1; wr_data = d; end
            4'd3: begin stat_wr = 1; wr_data = d; end
            4'd4: vec_rd = 1;
            4'd5: begin test_wr = 1; wr_data = d; end
            default: ;
        endcase
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        bus_busy = 0;
        srst = 1;
        repeat (3) @(negedge clk);
        srst = 0;
        // R1 reset state
        chk("R1 stat", stat_rdata, 0);
        chk("R1 mask", mask_rdata, 0);
        chk("R1 dma", dma_rdata, 0);
        chk("R1 outs", {irq, dma_rx_req, dma_tx_req, vec_code}, 0);

        for (int i = 0; i < NROWS; i++) begin
            do_op(TBL[i][55:52], TBL[i][51:36]);
            chk($sformatf("R5 R6 R9 R11 stat row%0d", i), stat_rdata, TBL[i][35:20]);
            chk($sformatf("R4 R8 mask row%0d", i), mask_rdata, TBL[i][19:12]);
            chk($sformatf("R5 code row%0d", i), vec_code, TBL[i][11:4]);
            chk($sformatf("R2 irq row%0d", i), irq, TBL[i][3]);
            chk($sformatf("R3 rx row%0d", i), dma_rx_req, TBL[i][2]);
            chk($sformatf("R3 tx row%0d", i), dma_tx_req, TBL[i][1]);
        end

        // R7 busy bit is live, stored bit 12 hidden
        do_op(4'd0, 16'h1000);
        chk("R7 busy low", stat_rdata[12], 0);
        bus_busy = 1; #1;
        chk("R7 busy high", stat_rdata[12], 1);
        bus_busy = 0;

        // R10 collisions: status holds 15,12,4,3
        do_op(4'd1, 16'h003F);
        chk("R10 pre code", vec_code, 4);
        vec_rd = 1; evt_set = 16'h0008;
        @(negedge clk); idle();
        chk("R10 vec vs set same bit", stat_rdata, 16'h8018);
        vec_rd = 1; evt_set = 16'h0001;
        @(negedge clk); idle();
        chk("R10 vec clears other bit", stat_rdata, 16'h8011);
        chk("R5 code after", vec_code, 1);
        stat_wr = 1; wr_data = 16'h0001; evt_set = 16'h0001;
        @(negedge clk); idle();
        chk("R10 w1c vs set", stat_rdata, 16'h8011);

        // R4 same-cycle mask and dma write
        mask_wr = 1; dma_wr = 1; wr_data = 16'h80BF;
        @(negedge clk); idle();
        chk("R4 mask after both", mask_rdata, 8'h27);
        chk("R4 dma kept bits", dma_rdata, 16'h8080);

        // R1 reset mid-run
        srst = 1; @(negedge clk); srst = 0;
        chk("R1 stat", stat_rdata, 0);
        chk("R1 mask dma", {mask_rdata, dma_rdata}, 0);
        chk("R1 outs", {irq, dma_rx_req, dma_tx_req, vec_code}, 0);

        // R8 older mask width
        do_op(4'd1, 16'h00FF);
        chk("R8 old mask", o_mask, 8'h1F);
        chk("R8 new mask", mask_rdata, 8'h3F);
        // R9 force only in newer variant
        do_op(4'd5, 16'h0800);
        chk("R9 old no force", o_stat, 0);
        chk("R9 new force", stat_rdata, 16'h003F);
        // R6 older ignores status write
        do_op(4'd0, 16'h0001);
        do_op(4'd3, 16'h0001);
        chk("R6 old w1c ignored", o_stat, 16'h0001);
        chk("R6 new w1c", stat_rdata, 16'h003E);
        chk("R2 old irq", o_irq, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule